// File: doc/BRIEF.md
# Rank-Based Clos Route Assigner

The block assigns middle-stage paths for a three-stage Clos fabric with `P` outer modules of `Q` ports each and `Q` middle modules. A port number `d` is read as `d = a*Q + b`, where `a` is the outer module and `b` is the port inside it. Connection requests arrive one per cycle as a batch whose sources and destinations both rise strictly. The block gives each request the middle module `(m + rank) mod Q`, where `rank` is the request's position in the batch counted from zero and `m` is an offset. Two batches that meet this ordering rule never collide inside the fabric, so no search for a free path is needed.

The first request of a batch is flagged. The block samples the offset on that cycle and restarts the rank count. One cycle after each request it emits a registered tag. The tag holds the middle module, the destination module and the destination port, and it echoes the source. It also carries the upper part of the rank, `rank div Q`. A recursive fabric passes that value to the next level down, while the middle choice serves as the lower digit. Batches hold at most `P*Q` requests. The block does not check whether a batch is monotonic.

Top module: `rank_clos_router`

## Requirements
- R1: After reset `tag_valid` is 0. A request that arrives before any flagged batch head is treated as rank 0 with offset 0.
- R2: Each cycle with `req_valid` high yields exactly one tag with `tag_valid` high on the next cycle. A cycle with `req_valid` low yields `tag_valid` low on the next cycle.
- R3: `tag_dmod` equals `req_dst div Q` and `tag_dport` equals `req_dst mod Q`.
- R4: A request with `req_first` high gets rank 0. Its tag has `tag_mid = req_offset mod Q` and `tag_hi = 0`.
- R5: The rank of a request without `req_first` is one more than the rank of the previous accepted request, and `tag_mid = (m + rank) mod Q`. Idle cycles do not change the rank.
- R6: `tag_hi` equals `rank div Q`.
- R7: `req_offset` is sampled only on a cycle where `req_valid` and `req_first` are both high. It has no effect on any other cycle.
- R8: `tag_src` repeats the request's source.
- R9: A flagged request restarts the rank at 0 even when the previous batch is still running, including on the cycle straight after one of its requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_first | input | 1 | The request starts a new batch |
| req_offset | input | QW | Offset m, sampled at the batch head |
| req_src | input | NW | Source port of the request |
| req_dst | input | NW | Destination port of the request |
| tag_valid | output | 1 | The tag outputs hold a result |
| tag_mid | output | QW | Assigned middle-stage module |
| tag_hi | output | PW | rank div Q, passed to a lower recursion level |
| tag_dmod | output | PW | Destination outer module index |
| tag_dport | output | QW | Port within the destination module |
| tag_src | output | NW | Source port echoed |

## Verification
Two functions of the block can act in the same cycle. The first is a batch restart that lands on the cycle straight after a running batch's request, where the reset of the rank competes with its increment. The second is an offset change that arrives together with a request that is not a batch head, where sampling competes with holding. The bench provokes both, with directed sequences and with random back-to-back batches that carry a new random offset on every cycle. It judges them against a model that restarts the rank only on flagged requests and keeps the offset latched at the batch head.

// File: rtl/clos_route_pkg.sv
package clos_route_pkg;
  // Next value of a counter that runs 0 .. lim-1 and wraps.
  function automatic int unsigned wrap_next(int unsigned v, int unsigned lim);
    return (v + 1 >= lim) ? 0 : v + 1;
  endfunction
endpackage

// File: rtl/clos_port_split.sv
module clos_port_split #(
  parameter int P = 3,
  parameter int Q = 4,
  localparam int NW = $clog2(P * Q),
  localparam int PW = (P > 1) ? $clog2(P) : 1,
  localparam int QW = (Q > 1) ? $clog2(Q) : 1
) (
  input  logic [NW-1:0] port_num,
  output logic [PW-1:0] mod_idx,
  output logic [QW-1:0] sub_idx
);
  logic [31:0] wide_num;
  assign wide_num = 32'(port_num);
  assign mod_idx  = PW'(wide_num / Q);
  assign sub_idx  = QW'(wide_num % Q);
endmodule

// File: rtl/clos_rank_seq.sv
module clos_rank_seq
  import clos_route_pkg::*;
#(
  parameter int P = 3,
  parameter int Q = 4,
  localparam int PW = (P > 1) ? $clog2(P) : 1,
  localparam int QW = (Q > 1) ? $clog2(Q) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          first,
  input  logic [QW-1:0] offset,
  output logic [QW-1:0] cur_mid,
  output logic [PW-1:0] cur_hi
);
  // State describes the request that comes next.
  logic [QW-1:0] nxt_lo, nxt_mid, cur_lo;
  logic [PW-1:0] nxt_hi;
  logic [QW-1:0] head_mid;

  assign head_mid = QW'(32'(offset) % Q);

  always_comb begin
    if (first) begin
      cur_lo  = '0;
      cur_hi  = '0;
      cur_mid = head_mid;
    end else begin
      cur_lo  = nxt_lo;
      cur_hi  = nxt_hi;
      cur_mid = nxt_mid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nxt_lo  <= '0;
      nxt_hi  <= '0;
      nxt_mid <= '0;
    end else if (adv) begin
      nxt_lo  <= QW'(wrap_next(32'(cur_lo), Q));
      nxt_mid <= QW'(wrap_next(32'(cur_mid), Q));
      nxt_hi  <= (32'(cur_lo) == Q - 1) ? cur_hi + 1'b1 : cur_hi;
    end
  end

  assert_lo_range_R6: assert property (@(posedge clk) disable iff (rst)
    32'(nxt_lo) < Q);
  assert_hi_carry_R6: assert property (@(posedge clk) disable iff (rst)
    (adv && 32'(cur_lo) == Q - 1) |=> nxt_hi == $past(cur_hi) + 1'b1);
  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !adv |=> ($stable(nxt_mid) && $stable(nxt_hi) && $stable(nxt_lo)));
endmodule

// File: rtl/rank_clos_router.sv
module rank_clos_router
  import clos_route_pkg::*;
#(
  parameter int P = 3,
  parameter int Q = 4,
  localparam int NW = $clog2(P * Q),
  localparam int PW = (P > 1) ? $clog2(P) : 1,
  localparam int QW = (Q > 1) ? $clog2(Q) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_first,
  input  logic [QW-1:0] req_offset,
  input  logic [NW-1:0] req_src,
  input  logic [NW-1:0] req_dst,
  output logic          tag_valid,
  output logic [QW-1:0] tag_mid,
  output logic [PW-1:0] tag_hi,
  output logic [PW-1:0] tag_dmod,
  output logic [QW-1:0] tag_dport,
  output logic [NW-1:0] tag_src
);
  logic [QW-1:0] mid_c;
  logic [PW-1:0] hi_c;
  logic [PW-1:0] dmod_c;
  logic [QW-1:0] dport_c;

  clos_rank_seq #(.P(P), .Q(Q)) u_seq (
    .clk    (clk),
    .rst    (rst),
    .adv    (req_valid),
    .first  (req_first),
    .offset (req_offset),
    .cur_mid(mid_c),
    .cur_hi (hi_c)
  );

  clos_port_split #(.P(P), .Q(Q)) u_split (
    .port_num(req_dst),
    .mod_idx (dmod_c),
    .sub_idx (dport_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tag_valid <= 1'b0;
      tag_mid   <= '0;
      tag_hi    <= '0;
      tag_dmod  <= '0;
      tag_dport <= '0;
      tag_src   <= '0;
    end else begin
      tag_valid <= req_valid;
      if (req_valid) begin
        tag_mid   <= mid_c;
        tag_hi    <= hi_c;
        tag_dmod  <= dmod_c;
        tag_dport <= dport_c;
        tag_src   <= req_src;
      end
    end
  end

  assert_tag_follows_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> tag_valid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !tag_valid);
  assert_split_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && 32'(req_dst) < P * Q) |=>
      (32'(tag_dmod) * Q + 32'(tag_dport)) == 32'($past(req_dst)));
  assert_batch_head_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_first) |=>
      (tag_hi == '0 && 32'(tag_mid) == 32'($past(req_offset)) % Q));
  assert_step_R5: assert property (@(posedge clk) disable iff (rst)
    (tag_valid && req_valid && !req_first) |=>
      32'(tag_mid) == wrap_next(32'($past(tag_mid)), Q));
  assert_src_echo_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> tag_src == $past(req_src));
endmodule

// File: tb/test_rank_clos_router.sv
module test_rank_clos_router;
  localparam int P  = 3;
  localparam int Q  = 4;
  localparam int N  = P * Q;
  localparam int NW = $clog2(N);
  localparam int PW = 2;
  localparam int QW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_first = 1'b0;
  logic [QW-1:0] req_offset = '0;
  logic [NW-1:0] req_src = '0, req_dst = '0;
  logic          tag_valid;
  logic [QW-1:0] tag_mid, tag_dport;
  logic [PW-1:0] tag_hi, tag_dmod;
  logic [NW-1:0] tag_src;

  rank_clos_router #(.P(P), .Q(Q)) i_rank_clos_router (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_first(req_first),
    .req_offset(req_offset), .req_src(req_src), .req_dst(req_dst),
    .tag_valid(tag_valid), .tag_mid(tag_mid), .tag_hi(tag_hi),
    .tag_dmod(tag_dmod), .tag_dport(tag_dport), .tag_src(tag_src));

  always #4 clk = ~clk;  // 125 MHz

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;
  int m_rank = 0, m_off = 0;
  bit p_valid = 0;
  int p_mid, p_hi, p_dmod, p_dport, p_src;
  string p_tag = "R5";

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic verify();
    chk(tag_valid == p_valid, "R2", "tag_valid", int'(tag_valid), int'(p_valid));
    if (p_valid) begin
      chk(int'(tag_mid) == p_mid, p_tag, "tag_mid", int'(tag_mid), p_mid);
      chk(int'(tag_hi) == p_hi, "R6", "tag_hi", int'(tag_hi), p_hi);
      chk(int'(tag_dmod) == p_dmod, "R3", "tag_dmod", int'(tag_dmod), p_dmod);
      chk(int'(tag_dport) == p_dport, "R3", "tag_dport", int'(tag_dport), p_dport);
      chk(int'(tag_src) == p_src, "R8", "tag_src", int'(tag_src), p_src);
    end
  endtask

  // Check the previous cycle's result, then drive the next request.
  task automatic step(input bit v, input bit f, input int off,
                      input int s, input int d, input string mtag);
    @(negedge clk);
    verify();
    req_valid  = v;
    req_first  = f;
    req_offset = QW'(off);
    req_src    = NW'(s);
    req_dst    = NW'(d);
    p_valid = v;
    p_tag   = mtag;
    if (v) begin
      if (f) begin
        m_rank = 0;
        m_off  = off % Q;
      end
      p_mid   = (m_off + m_rank) % Q;
      p_hi    = m_rank / Q;
      p_dmod  = d / Q;
      p_dport = d % Q;
      p_src   = s;
      m_rank++;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog: actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(tag_valid == 1'b0, "R1", "tag_valid in reset", int'(tag_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(tag_valid == 1'b0, "R1", "tag_valid after reset", int'(tag_valid), 0);

    // R1: no batch head yet, offset input must be ignored (R7).
    step(1, 0, 2, 5, 7, "R1");
    // R4 head with offset 3, then R5 steps with a changing offset (R7).
    step(1, 1, 3, 0, 1, "R4");
    step(1, 0, 1, 2, 3, "R7");
    step(1, 0, 2, 3, 4, "R7");
    step(0, 0, 0, 0, 0, "R5");
    step(0, 1, 1, 0, 0, "R5");   // flagged but not valid: no restart
    step(1, 0, 0, 4, 6, "R5");
    step(1, 0, 2, 6, 9, "R5");   // rank 4: hi becomes 1 (R6)
    step(1, 0, 1, 9, 11, "R5");
    // R9: restart on the cycle straight after a running batch's request.
    step(1, 1, 1, 1, 0, "R9");
    step(1, 0, 3, 2, 5, "R9");

    for (int b = 0; b < 40; b++) begin
      int s = $urandom % 3;
      int d = $urandom % 3;
      int len = 1 + $urandom % N;
      for (int k = 0; k < len; k++) begin
        if (s >= N || d >= N) break;
        if ($urandom % 4 == 0) step(0, $urandom % 2, $urandom % 4, 0, 0, "R5");
        step(1, k == 0, $urandom % 4, s, d, (k == 0) ? "R4" : "R7");
        s += 1 + $urandom % 2;
        d += 1 + $urandom % 2;
      end
    end
    step(0, 0, 0, 0, 0, "R5");
    @(negedge clk);
    verify();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule